// File: doc/BRIEF.md
# Root-Port Interrupt Collector

This block gathers the interrupt sources of a root port onto a single interrupt line toward the host. It accepts two kinds of source. Message-signalled interrupts arrive as inbound posted writes: when the write address matches a programmable 32-bit capture address, the write data selects one of 32 vectors, and that vector's pending bit is latched. Four legacy INTx inputs are sampled every cycle, and an input that is high latches its own pending bit.

Message interrupts are kept on two levels. A per-vector status register holds one bit per vector. A summary bit in the top-level status register reports that at least one vector has fired. Software clears both levels with write-one-to-clear writes. It clears the vector bits first and then the summary. The summary refuses to clear while any vector bit is still pending, so no pending vector is hidden from the host. A mask register gates each top-level source onto the host line. All masks reset to the masked state.

Top module: `irq_collector`

## Requirements
- R1: An accepted inbound write (valid high, address equal to the capture address, data below 32) sets the per-vector status bit whose index is the write data. The bit reads back as set from the cycle after the write.
- R2: The capture address is one 32-bit register at register address 0. It resets to 0 and reads back the last value written, from the next cycle on.
- R3: The per-vector status register is at register address 3. Writing a 1 to a bit clears that bit. A 0 leaves the bit unchanged.
- R4: The top-level status register is at register address 2. Bits [19:16] latch INTx inputs 0..3 on every cycle the input is high. Writing a 1 to one of these bits clears it, but an input that is high in the same cycle wins over the clear. The other bits read 0, apart from bit 23.
- R5: The mask register is at register address 1. Bits [19:16] mask INTx 0..3 and bit 23 masks the message summary. These bits reset to 1, meaning masked, and a 0 enables the source. All other bits are not stored and read 0.
- R6: The message summary bit is bit 23 of the top-level status register. It is set in the cycle after any accepted inbound write, even when a write-one-to-clear of bit 23 arrives in the same cycle.
- R7: Writing a 1 to summary bit 23 has no effect while any per-vector bit is still pending after that cycle's update. The clear works once no vector bit is pending.
- R8: The host interrupt output is high exactly when some top-level status bit is set and its mask bit is 0.
- R9: Inbound writes with data of 32 or more, with an address other than the capture address, or with valid low change no status bit.
- R10: When an accepted inbound write and a write-one-to-clear hit the same vector bit in the same cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inbound posted write is present this cycle |
| in_addr | input | 32 | Inbound write address |
| in_data | input | 32 | Inbound write data; the vector number |
| intx_in | input | 4 | Legacy INTx inputs 0..3, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 capture address, 1 mask, 2 top status, 3 vector status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register selected by reg_addr, valid in the same cycle |
| host_irq | output | 1 | Interrupt line to the host |

## Verification
The bench builds the block with its default parameters: 32 vectors, 32-bit address and data, and four INTx lines at bits [19:16]. With these values the top vector (31) and the first out-of-range value (32) are both reachable, so the boundary of the vector index is exercised from both sides. The real bit positions that software sees in the status and mask registers are also in place. A behavioural model is stepped every clock, and the output line and the selected register are compared against it. The stimulus aims at set/clear collisions on the vector bits, on the summary and on the INTx bits.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // register select codes; software depends on these
  typedef enum logic [1:0] {
    SEL_CAPADDR = 2'd0,
    SEL_MASK    = 2'd1,
    SEL_TOPSTAT = 2'd2,
    SEL_VECSTAT = 2'd3
  } reg_sel_e;

  // field positions in the top status and mask registers
  localparam int INTX_LSB = 16;
  localparam int SUM_BIT  = 23;

  // returns 1 when a data word names a vector inside the bank
  function automatic logic vec_in_range(input logic [31:0] data, input int nvec);
    return data < 32'(nvec);
  endfunction
endpackage

// File: rtl/msi_vec_bank.sv
module msi_vec_bank #(
  parameter int NUM_VEC = 32,
  localparam int IDX_W = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit,
  input  logic [IDX_W-1:0]   hit_idx,
  input  logic [NUM_VEC-1:0] vec_clr,
  input  logic               sum_clr,
  output logic [NUM_VEC-1:0] vec_q,
  output logic               sum_q
);
  logic [NUM_VEC-1:0] vec_d;

  generate
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      logic set_v;
      assign set_v    = hit && (hit_idx == IDX_W'(v));
      // set wins over clear
      assign vec_d[v] = set_v | (vec_q[v] & ~vec_clr[v]);
    end
  endgenerate

  logic sum_d;
  // the summary drops only when nothing remains pending
  assign sum_d = hit | (sum_clr ? (|vec_d) : sum_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      sum_q <= 1'b0;
    end else begin
      vec_q <= vec_d;
      sum_q <= sum_d;
    end
  end

  // R1 / R10: an accepted write leaves its vector bit set
  a_r1_vec_set: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> vec_q[$past(hit_idx)]);
  // R6: summary follows any accepted write
  a_r6_sum_set: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> sum_q);
  // R7: a pending vector is never hidden
  a_r7_no_hide: assert property (@(posedge clk) disable iff (!rst_n)
    (|vec_q) |-> sum_q);
  // R9: without a hit or a clear the vector bank holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && vec_clr == '0) |=> $stable(vec_q));
endmodule

// File: rtl/intx_latch.sv
module intx_latch #(
  parameter int NUM_INTX = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_INTX-1:0] intx_in,
  input  logic [NUM_INTX-1:0] intx_clr,
  output logic [NUM_INTX-1:0] intx_q
);
  generate
    for (genvar i = 0; i < NUM_INTX; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) intx_q[i] <= 1'b0;
        else        intx_q[i] <= intx_in[i] | (intx_q[i] & ~intx_clr[i]);
      end

      // R4: a high input is latched even against a clear
      a_r4_intx_latch: assert property (@(posedge clk) disable iff (!rst_n)
        intx_in[i] |=> intx_q[i]);
    end
  endgenerate
endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irqc_pkg::*;
#(
  parameter int NUM_VEC  = 32,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_INTX = 4,
  localparam int IDX_W   = $clog2(NUM_VEC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic [DATA_W-1:0]   in_data,
  input  logic [NUM_INTX-1:0] intx_in,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                host_irq
);
  logic [ADDR_W-1:0]   cap_addr_q;
  logic [NUM_INTX-1:0] intx_mask_q;
  logic                sum_mask_q;

  // named events used by the assertions
  logic wr_cap, wr_mask, wr_top, wr_vec;
  assign wr_cap  = reg_wr && (reg_addr == SEL_CAPADDR);
  assign wr_mask = reg_wr && (reg_addr == SEL_MASK);
  assign wr_top  = reg_wr && (reg_addr == SEL_TOPSTAT);
  assign wr_vec  = reg_wr && (reg_addr == SEL_VECSTAT);

  logic msi_hit;
  assign msi_hit = in_valid && (in_addr == cap_addr_q)
                   && vec_in_range(32'(in_data), NUM_VEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr_q  <= '0;
      intx_mask_q <= '1;
      sum_mask_q  <= 1'b1;
    end else begin
      if (wr_cap) cap_addr_q <= reg_wdata[ADDR_W-1:0];
      if (wr_mask) begin
        intx_mask_q <= reg_wdata[INTX_LSB +: NUM_INTX];
        sum_mask_q  <= reg_wdata[SUM_BIT];
      end
    end
  end

  logic [NUM_VEC-1:0]  vec_q;
  logic                sum_q;
  logic [NUM_INTX-1:0] intx_q;

  msi_vec_bank #(.NUM_VEC(NUM_VEC)) u_vec (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (msi_hit),
    .hit_idx (in_data[IDX_W-1:0]),
    .vec_clr (wr_vec ? reg_wdata[NUM_VEC-1:0] : '0),
    .sum_clr (wr_top && reg_wdata[SUM_BIT]),
    .vec_q   (vec_q),
    .sum_q   (sum_q)
  );

  intx_latch #(.NUM_INTX(NUM_INTX)) u_intx (
    .clk      (clk),
    .rst_n    (rst_n),
    .intx_in  (intx_in),
    .intx_clr (wr_top ? reg_wdata[INTX_LSB +: NUM_INTX] : '0),
    .intx_q   (intx_q)
  );

  logic [DATA_W-1:0] top_word, mask_word;
  always_comb begin
    top_word  = '0;
    mask_word = '0;
    top_word[INTX_LSB +: NUM_INTX]  = intx_q;
    top_word[SUM_BIT]               = sum_q;
    mask_word[INTX_LSB +: NUM_INTX] = intx_mask_q;
    mask_word[SUM_BIT]              = sum_mask_q;
  end

  always_comb begin
    unique case (reg_addr)
      SEL_CAPADDR: reg_rdata = DATA_W'(cap_addr_q);
      SEL_MASK:    reg_rdata = mask_word;
      SEL_TOPSTAT: reg_rdata = top_word;
      default:     reg_rdata = DATA_W'(vec_q);
    endcase
  end

  assign host_irq = |(intx_q & ~intx_mask_q) | (sum_q & ~sum_mask_q);

  // R8: a masked-off source alone never raises the line
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (intx_mask_q == '1 && sum_mask_q) |-> !host_irq);
  // R2: capture address follows its register write
  a_r2_capaddr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cap |=> cap_addr_q == $past(reg_wdata[ADDR_W-1:0]));
endmodule

// File: tb/irq_collector_test.sv
module irq_collector_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic [3:0]  intx_in = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        host_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_collector uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_data(in_data), .intx_in(intx_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .host_irq(host_irq)
  );

  // behavioural reference
  logic [31:0] m_cap;
  logic [31:0] m_vec;
  bit          m_sum;
  logic [3:0]  m_intx;
  logic [3:0]  m_imask;
  bit          m_smask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cap = 0; m_vec = 0; m_sum = 0; m_intx = 0; m_imask = 4'hF; m_smask = 1;
    end else begin
      bit accept;
      logic [31:0] nvec;
      accept = in_valid && in_addr == m_cap && in_data < 32;
      nvec = m_vec;
      if (reg_wr && reg_addr == 3) nvec = nvec & ~reg_wdata;
      if (accept) nvec[in_data[4:0]] = 1'b1;
      if (accept) m_sum = 1;
      else if (reg_wr && reg_addr == 2 && reg_wdata[23]) m_sum = (nvec != 0);
      if (reg_wr && reg_addr == 2) m_intx = m_intx & ~reg_wdata[19:16];
      m_intx = m_intx | intx_in;
      if (reg_wr && reg_addr == 0) m_cap = reg_wdata;
      if (reg_wr && reg_addr == 1) begin
        m_imask = reg_wdata[19:16]; m_smask = reg_wdata[23];
      end
      m_vec = nvec;
    end
  end

  function automatic logic [31:0] m_read(input logic [1:0] a);
    logic [31:0] w;
    w = 0;
    case (a)
      2'd0: w = m_cap;
      2'd1: begin w[19:16] = m_imask; w[23] = m_smask; end
      2'd2: begin w[19:16] = m_intx; w[23] = m_sum; end
      default: w = m_vec;
    endcase
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison of the line and the selected register
  always @(negedge clk) begin
    if (rst_n && !done) begin
      string t;
      bit exp_irq;
      exp_irq = (|(m_intx & ~m_imask)) || (m_sum && !m_smask);
      check("R8 host_irq", {31'b0, host_irq}, {31'b0, exp_irq});
      case (reg_addr)
        2'd0: t = "R2 capture address";
        2'd1: t = "R5 mask";
        2'd2: t = "R4 R6 R7 top status";
        default: t = "R1 R3 R9 R10 vector status";
      endcase
      check(t, reg_rdata, m_read(reg_addr));
    end
  end

  task automatic tick(input bit w, input logic [1:0] a, input logic [31:0] d,
                      input bit v, input logic [31:0] ia, input logic [31:0] id,
                      input logic [3:0] ix);
    reg_wr = w; reg_addr = a; reg_wdata = d;
    in_valid = v; in_addr = ia; in_data = id; intx_in = ix;
    @(negedge clk); #1;
  endtask

  task automatic idle(input logic [1:0] a);
    tick(0, a, 0, 0, 0, 0, 0);
  endtask

  localparam logic [31:0] CAP = 32'h1000_0040;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // reset state of every register (R2, R5)
    for (int a = 0; a < 4; a++) idle(2'(a));
    check("R5 mask reset", reg_rdata, 32'h0);
    reg_addr = 1; #1;
    check("R5 mask reset value", reg_rdata, 32'h008F_0000);
    // R2 program capture address
    tick(1, 0, CAP, 0, 0, 0, 0);
    idle(0);
    check("R2 capture readback", reg_rdata, CAP);
    // R1 hit vector 5, still masked
    tick(0, 3, 0, 1, CAP, 5, 0);
    idle(3);
    check("R1 vector 5 set", reg_rdata, 32'h20);
    check("R8 masked line low", {31'b0, host_irq}, 0);
    // R5 unmask the summary only
    tick(1, 1, 32'h000F_0000, 0, 0, 0, 0);
    idle(2);
    check("R8 line high after unmask", {31'b0, host_irq}, 1);
    // R9 ignored writes: data 32, other address, valid low
    tick(0, 3, 0, 1, CAP, 32, 0);
    tick(0, 3, 0, 1, CAP + 4, 7, 0);
    tick(0, 3, 0, 0, CAP, 9, 0);
    idle(3);
    check("R9 ignored writes", reg_rdata, 32'h20);
    // R1 boundary vectors 31 and 0
    tick(0, 3, 0, 1, CAP, 31, 0);
    tick(0, 3, 0, 1, CAP, 0, 0);
    idle(3);
    check("R1 vectors 31 and 0", reg_rdata, 32'h8000_0021);
    // R7 summary clear while pending has no effect
    tick(1, 2, 32'h0080_0000, 0, 0, 0, 0);
    idle(2);
    check("R7 summary kept", reg_rdata, 32'h0080_0000);
    // R10 clear bits 5 and 0 while vector 5 arrives again; R3 bit 0 clears
    tick(1, 3, 32'h21, 1, CAP, 5, 0);
    idle(3);
    check("R10 R3 set wins", reg_rdata, 32'h8000_0020);
    // R3 clear the rest, then R7 summary clears
    tick(1, 3, 32'hFFFF_FFFF, 0, 0, 0, 0);
    tick(1, 2, 32'h0080_0000, 0, 0, 0, 0);
    idle(2);
    check("R7 summary cleared", reg_rdata, 32'h0);
    check("R8 line low", {31'b0, host_irq}, 0);
    // R6 hit in the same cycle as a summary clear
    tick(1, 2, 32'h0080_0000, 1, CAP, 12, 0);
    idle(2);
    check("R6 set over clear", reg_rdata, 32'h0080_0000);
    tick(1, 3, 32'h0000_1000, 0, 0, 0, 0);
    tick(1, 2, 32'h0080_0000, 0, 0, 0, 0);
    // R4 INTx latch, masked then unmasked
    tick(0, 2, 0, 0, 0, 0, 4'b0100);
    idle(2);
    check("R4 intx2 latched", reg_rdata, 32'h0004_0000);
    check("R8 intx masked", {31'b0, host_irq}, 0);
    tick(1, 1, 32'h008B_0000, 0, 0, 0, 0);
    idle(2);
    check("R8 intx2 unmasked", {31'b0, host_irq}, 1);
    // R4 clear while line held high keeps the bit, then clears
    tick(1, 2, 32'h0004_0000, 0, 0, 0, 4'b0100);
    idle(2);
    check("R4 held input wins", reg_rdata, 32'h0004_0000);
    tick(1, 2, 32'h0004_0000, 0, 0, 0, 0);
    idle(2);
    check("R4 intx cleared", reg_rdata, 32'h0);
    // R4 multiple lines, partial clear
    tick(0, 2, 0, 0, 0, 0, 4'b1001);
    tick(1, 2, 32'h0001_0000, 0, 0, 0, 0);
    idle(2);
    check("R4 partial clear", reg_rdata, 32'h0008_0000);
    // R2 reprogram, old address now ignored
    tick(1, 0, 32'hDEAD_BEE0, 0, 0, 0, 0);
    tick(0, 3, 0, 1, CAP, 3, 0);
    idle(3);
    check("R9 old address ignored", reg_rdata, 32'h0);
    tick(0, 3, 0, 1, 32'hDEAD_BEE0, 3, 0);
    idle(3);
    check("R1 new address accepted", reg_rdata, 32'h8);
    repeat (4) idle(1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule